// File: doc/BRIEF.md
# Refresh-Concurrent Memory Consistency Checker

This block wraps a small bit-addressed storage array, organised as rows of cells with a single row buffer, and checks its contents for silent corruption while the array is being refreshed. Each cell has a bit address made of a row part (upper bits) and a column part (lower bits). The block keeps two signatures of the array. Each signature is the XOR of the bit addresses of all cells that hold a one. The reference signature tracks the intended contents: every write feeds the row once before and once after the modification, so the signature moves by exactly the address of each cell that changed. The test signature is rebuilt from scratch by a refresh walk that reads every row through the buffer and writes it back.

A row's share of a signature is computed in one step. The row part is the row index if the row holds an odd number of ones and zero otherwise. The column part is the XOR of the column indices of the ones. At the end of a walk the two signatures are compared. A mismatch raises the error flag, and their XOR is reported as a diagnostic address. For a single upset cell that value is the cell's address. Requests that arrive during a walk are served between row steps, and the walk then resumes. If the request writes a row that the walk has already folded in, the test signature receives the same adjustment as the reference signature.

A fault-injection input flips one stored bit without passing through the update logic, so that detection can be exercised.

Top module: `refresh_sig_checker`

## Requirements
- R1: After reset, every cell reads zero, both signatures are zero, `err_flag` is 0, `diag_addr` is 0 and `req_ready` is 1.
- R2: A read returns the last value written to the addressed cell. Bit address = {row, column}, with the row in the upper log2(ROWS) bits. `op_done` pulses for one cycle with `rd_data` valid when a request completes.
- R3: With no injected faults, any sequence of writes followed by a refresh walk reports `err_flag`=0 and `diag_addr`=0.
- R4: A write that stores the value the cell already holds leaves both signatures unchanged. Reads never change them either.
- R5: A refresh walk visits rows 0 to ROWS-1 in order, and each row step takes two cycles. After the last row, `walk_done` pulses for one cycle.
- R6: If exactly one cell at a nonzero address has been flipped since the signatures last agreed, the next walk reports `err_flag`=1 and `diag_addr` equal to that address. At each `walk_done`, `err_flag` is 1 exactly when `diag_addr` is nonzero.
- R7: Two flipped cells at distinct addresses a and b give `err_flag`=1 and `diag_addr` = a XOR b.
- R8: A flip of the cell at address 0 adds nothing to either signature, so the walk reports `err_flag`=0.
- R9: `err_flag` and `diag_addr` change only in the cycle `walk_done` is high. Between walks they hold their values.
- R10: A write during a walk to a row below the current row counter adjusts the test signature as it does the reference. A write to a row at or above the counter leaves the test signature alone. The walk then resumes at the same row counter value, and the walk reports no error.
- R11: In the idle state a request takes priority over `refresh_go`, and a `refresh_go` that is not taken is dropped. `op_done` and `walk_done` never pulse together.
- R12: The test signature is cleared when a walk starts. After a flipped cell is flipped back, the next walk reports `err_flag`=0.

States: S_IDLE (waiting; a request moves to S_OP_LOAD, `refresh_go` moves to S_RF_LOAD), S_OP_LOAD (row into buffer), S_OP_OLD (fold old row, modify buffer), S_OP_NEW (fold new row, write back, then to S_RF_LOAD if walking else S_IDLE), S_RF_LOAD (a request moves to S_OP_LOAD, otherwise the counter row is loaded and the state moves to S_RF_STEP), S_RF_STEP (fold row into test signature, write back, then to S_RF_CMP on the last row or back to S_RF_LOAD), S_RF_CMP (compare, publish, then to S_IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears array and signatures |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | log2(ROWS*COLS) | Bit address {row, column} |
| req_wdata | input | 1 | Write bit |
| refresh_go | input | 1 | Start a refresh walk (taken in idle only) |
| flip_en | input | 1 | Fault injection: invert one stored bit |
| flip_addr | input | log2(ROWS*COLS) | Bit address to invert |
| req_ready | output | 1 | Request can be taken this cycle |
| op_done | output | 1 | One-cycle pulse when a request completes |
| rd_data | output | 1 | Read result, valid with op_done |
| walk_done | output | 1 | One-cycle pulse at the end of a walk |
| err_flag | output | 1 | Signatures differed at the last walk |
| diag_addr | output | log2(ROWS*COLS) | XOR of the two signatures at the last walk |

## Verification
The bench targets writes that land mid-walk on rows both behind and ahead of the row counter. A design that adjusts the test signature in both cases, or in neither, reports the written cell's address as a spurious error. Rewriting an unchanged value and injecting at address 0 are exercised: a compressor that folds the written bit instead of the difference, or that gives address 0 some weight, shows a false error. Single and double upsets check that the diagnostic equals the address or the address XOR. A test signature that is not cleared at walk start keeps reporting an error after the fault is repaired. Flags are checked across later operations to catch a design that republishes them outside walk completion.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_OP_LOAD,
        S_OP_OLD,
        S_OP_NEW,
        S_RF_LOAD,
        S_RF_STEP,
        S_RF_CMP
    } ctl_state_t;
endpackage

// File: rtl/rsc_row_array.sv
module rsc_row_array #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_row,
    output logic [COLS-1:0] rd_bits,
    input  logic            wb_en,
    input  logic [RW-1:0]   wb_row,
    input  logic [COLS-1:0] wb_bits,
    input  logic            flip_en,
    input  logic [RW-1:0]   flip_row,
    input  logic [CW-1:0]   flip_col
);
    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] flip_mask;

    assign flip_mask = COLS'(1) << flip_col;
    assign rd_bits   = cells[rd_row];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] base;
        logic [COLS-1:0] upset;

        always_comb begin
            base  = (wb_en && wb_row == RW'(r)) ? wb_bits : cells[r];
            upset = (flip_en && flip_row == RW'(r)) ? flip_mask : '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cells[r] <= '0;
            else        cells[r] <= base ^ upset;
        end
    end
endmodule

// File: rtl/rsc_row_compressor.sv
module rsc_row_compressor #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic [RW-1:0]    row_idx,
    input  logic [COLS-1:0]  bits,
    output logic [RW+CW-1:0] sig
);
    logic odd_row;

    assign odd_row          = ^bits;
    assign sig[RW+CW-1:CW]  = odd_row ? row_idx : '0;

    for (genvar k = 0; k < CW; k++) begin : g_colbit
        logic [COLS-1:0] sel;
        always_comb begin
            for (int c = 0; c < COLS; c++) sel[c] = c[k];
        end
        assign sig[k] = ^(bits & sel);
    end
endmodule

// File: rtl/refresh_sig_checker.sv
module refresh_sig_checker
    import rsc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int AW = RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wdata,
    input  logic          refresh_go,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    output logic          req_ready,
    output logic          op_done,
    output logic          rd_data,
    output logic          walk_done,
    output logic          err_flag,
    output logic [AW-1:0] diag_addr
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    ctl_state_t state, nxt;

    logic [RW-1:0]   op_row;
    logic [CW-1:0]   op_col;
    logic            op_we;
    logic            op_wdata;
    logic [RW-1:0]   row_ctr;
    logic            walking;
    logic [COLS-1:0] rbuf;
    logic [AW-1:0]   ref_sig;
    logic [AW-1:0]   tst_sig;

    logic            accept;
    logic            passed;
    logic [RW-1:0]   rd_row;
    logic [COLS-1:0] rd_bits;
    logic [RW-1:0]   cmp_row;
    logic [AW-1:0]   row_sig;
    logic            wb_en;
    logic [RW-1:0]   wb_row;

    assign req_ready = (state == S_IDLE) || (state == S_RF_LOAD);
    assign accept    = req_ready && req_valid;
    assign passed    = walking && (op_row < row_ctr);
    assign rd_row    = (state == S_RF_LOAD) ? row_ctr : op_row;
    assign cmp_row   = (state == S_RF_STEP) ? row_ctr : op_row;
    assign wb_en     = (state == S_OP_NEW) || (state == S_RF_STEP);
    assign wb_row    = (state == S_RF_STEP) ? row_ctr : op_row;

    rsc_row_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_row   (rd_row),
        .rd_bits  (rd_bits),
        .wb_en    (wb_en),
        .wb_row   (wb_row),
        .wb_bits  (rbuf),
        .flip_en  (flip_en),
        .flip_row (flip_addr[AW-1:CW]),
        .flip_col (flip_addr[CW-1:0])
    );

    rsc_row_compressor #(.ROWS(ROWS), .COLS(COLS)) u_comp (
        .row_idx (cmp_row),
        .bits    (rbuf),
        .sig     (row_sig)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept)          nxt = S_OP_LOAD;
                else if (refresh_go) nxt = S_RF_LOAD;
            end
            S_OP_LOAD: nxt = S_OP_OLD;
            S_OP_OLD:  nxt = S_OP_NEW;
            S_OP_NEW:  nxt = walking ? S_RF_LOAD : S_IDLE;
            S_RF_LOAD: nxt = accept ? S_OP_LOAD : S_RF_STEP;
            S_RF_STEP: nxt = (row_ctr == LAST_ROW) ? S_RF_CMP : S_RF_LOAD;
            S_RF_CMP:  nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_row    <= '0;
            op_col    <= '0;
            op_we     <= 1'b0;
            op_wdata  <= 1'b0;
            row_ctr   <= '0;
            walking   <= 1'b0;
            rbuf      <= '0;
            ref_sig   <= '0;
            tst_sig   <= '0;
            op_done   <= 1'b0;
            rd_data   <= 1'b0;
            walk_done <= 1'b0;
            err_flag  <= 1'b0;
            diag_addr <= '0;
        end else begin
            op_done   <= 1'b0;
            walk_done <= 1'b0;
            if (accept) begin
                op_row   <= req_addr[AW-1:CW];
                op_col   <= req_addr[CW-1:0];
                op_we    <= req_we;
                op_wdata <= req_wdata;
            end
            unique case (state)
                S_IDLE: begin
                    if (!accept && refresh_go) begin
                        tst_sig <= '0;
                        row_ctr <= '0;
                        walking <= 1'b1;
                    end
                end
                S_OP_LOAD: rbuf <= rd_bits;
                S_OP_OLD: begin
                    if (op_we) begin
                        ref_sig      <= ref_sig ^ row_sig;
                        if (passed) tst_sig <= tst_sig ^ row_sig;
                        rbuf[op_col] <= op_wdata;
                    end
                end
                S_OP_NEW: begin
                    if (op_we) begin
                        ref_sig <= ref_sig ^ row_sig;
                        if (passed) tst_sig <= tst_sig ^ row_sig;
                    end
                    rd_data <= rbuf[op_col];
                    op_done <= 1'b1;
                end
                S_RF_LOAD: begin
                    if (!accept) rbuf <= rd_bits;
                end
                S_RF_STEP: begin
                    tst_sig <= tst_sig ^ row_sig;
                    if (row_ctr != LAST_ROW) row_ctr <= row_ctr + 1'b1;
                end
                S_RF_CMP: begin
                    err_flag  <= (tst_sig != ref_sig);
                    diag_addr <= tst_sig ^ ref_sig;
                    walk_done <= 1'b1;
                    walking   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker
    import rsc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int AW = RW + $clog2(COLS)
) (
    input logic          clk,
    input logic          rst_n,
    input ctl_state_t    state,
    input logic          req_valid,
    input logic          refresh_go,
    input logic          op_we,
    input logic          walking,
    input logic [RW-1:0] op_row,
    input logic [RW-1:0] row_ctr,
    input logic [AW-1:0] ref_sig,
    input logic [AW-1:0] tst_sig,
    input logic          op_done,
    input logic          walk_done,
    input logic          err_flag,
    input logic [AW-1:0] diag_addr
);
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_done |-> ($stable(err_flag) && $stable(diag_addr))); // R9

    AST_ERR_MATCHES_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (err_flag == (diag_addr != '0))); // R6

    AST_READ_NO_REF_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_OP_OLD || state == S_OP_NEW) && !op_we) |=> $stable(ref_sig)); // R4

    AST_AHEAD_NO_ADJUST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OP_OLD && !(walking && op_row < row_ctr)) |=> $stable(tst_sig)); // R10

    AST_WALK_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OP_OLD) |=> $stable(row_ctr)); // R10

    AST_WALK_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !req_valid && refresh_go) |=> (tst_sig == '0 && row_ctr == '0)); // R12

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_done, walk_done})); // R11
endmodule

bind refresh_sig_checker rsc_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .req_valid  (req_valid),
    .refresh_go (refresh_go),
    .op_we      (op_we),
    .walking    (walking),
    .op_row     (op_row),
    .row_ctr    (row_ctr),
    .ref_sig    (ref_sig),
    .tst_sig    (tst_sig),
    .op_done    (op_done),
    .walk_done  (walk_done),
    .err_flag   (err_flag),
    .diag_addr  (diag_addr)
);

// File: tb/refresh_sig_checker_test.sv
module refresh_sig_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;   // 8 rows x 8 columns
    localparam int NV = 12;

    // vector: {we, addr[5:0], wdata, expected read}
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 6'h09, 1'b1, 1'b0},
        {1'b1, 6'h0A, 1'b1, 1'b0},
        {1'b0, 6'h09, 1'b0, 1'b1},
        {1'b0, 6'h0B, 1'b0, 1'b0},
        {1'b1, 6'h3F, 1'b1, 1'b0},
        {1'b1, 6'h09, 1'b0, 1'b0},
        {1'b0, 6'h09, 1'b0, 1'b0},
        {1'b1, 6'h0A, 1'b1, 1'b0},
        {1'b0, 6'h0A, 1'b0, 1'b1},
        {1'b1, 6'h20, 1'b1, 1'b0},
        {1'b0, 6'h3F, 1'b0, 1'b1},
        {1'b0, 6'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic refresh_go = 1'b0;
    logic flip_en = 1'b0;
    logic [AW-1:0] flip_addr = '0;
    logic req_ready, op_done, rd_data, walk_done, err_flag;
    logic [AW-1:0] diag_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sig_checker #(.ROWS(8), .COLS(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .refresh_go(refresh_go),
        .flip_en(flip_en), .flip_addr(flip_addr), .req_ready(req_ready),
        .op_done(op_done), .rd_data(rd_data), .walk_done(walk_done),
        .err_flag(err_flag), .diag_addr(diag_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [AW-1:0] a, input logic d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!op_done) @(negedge clk);
    endtask

    task automatic start_walk();
        @(negedge clk);
        refresh_go = 1'b1;
        @(negedge clk);
        refresh_go = 1'b0;
    endtask

    task automatic wait_walk();
        while (!walk_done) @(negedge clk);
    endtask

    task automatic flip(input logic [AW-1:0] a);
        @(negedge clk);
        flip_en = 1'b1; flip_addr = a;
        @(negedge clk);
        flip_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 err_flag", err_flag, 0);
        check("R1 diag_addr", diag_addr, 0);
        check("R1 req_ready", req_ready, 1);
        do_op(1'b0, 6'h15, 1'b0);
        check("R1 cell reads zero", rd_data, 0);

        // R2 vector table, R4 rewrite of equal value at entry 7
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][8], VEC[i][7:2], VEC[i][1]);
            if (!VEC[i][8]) check("R2 read data", rd_data, VEC[i][0]);
        end

        // R3, R4, R5: no faults -> clean walk
        start_walk();
        wait_walk();
        check("R5 walk_done pulse", walk_done, 1);
        check("R3 err_flag clean", err_flag, 0);
        check("R3 diag clean", diag_addr, 0);
        @(negedge clk);
        check("R5 walk_done one cycle", walk_done, 0);

        // R6 single upset diagnosed
        flip(6'h2B);
        start_walk();
        wait_walk();
        check("R6 err_flag single", err_flag, 1);
        check("R6 diag single", diag_addr, 32'h2B);

        // R9 flags held across later operations
        do_op(1'b1, 6'h11, 1'b1);
        check("R9 err held", err_flag, 1);
        check("R9 diag held", diag_addr, 32'h2B);
        do_op(1'b0, 6'h2B, 1'b0);
        check("R6 upset cell visible", rd_data, 1);

        // R12 repair then clean walk
        flip(6'h2B);
        start_walk();
        wait_walk();
        check("R12 err after repair", err_flag, 0);
        check("R12 diag after repair", diag_addr, 0);

        // R7 double upset
        flip(6'h05);
        flip(6'h30);
        start_walk();
        wait_walk();
        check("R7 err_flag double", err_flag, 1);
        check("R7 diag double", diag_addr, 32'h35);
        flip(6'h05);
        flip(6'h30);
        start_walk();
        wait_walk();
        check("R7 repaired", err_flag, 0);

        // R8 address-0 upset not visible
        flip(6'h00);
        start_walk();
        wait_walk();
        check("R8 err_flag addr0", err_flag, 0);
        check("R8 diag addr0", diag_addr, 0);
        flip(6'h00);

        // R10 writes during a walk: row behind counter, then row ahead
        start_walk();
        repeat (7) @(negedge clk);
        do_op(1'b1, 6'h0C, 1'b1);   // row 1, already passed
        do_op(1'b1, 6'h3A, 1'b1);   // row 7, not reached
        wait_walk();
        check("R10 err_flag mid-walk writes", err_flag, 0);
        check("R10 diag mid-walk writes", diag_addr, 0);
        do_op(1'b0, 6'h0C, 1'b0);
        check("R10 passed-row write stored", rd_data, 1);
        do_op(1'b0, 6'h3A, 1'b0);
        check("R10 ahead-row write stored", rd_data, 1);

        // R11 request wins over simultaneous refresh_go
        begin
            int seen_op = 0;
            int seen_walk = 0;
            @(negedge clk);
            req_valid = 1'b1; req_we = 1'b0; req_addr = 6'h3F; refresh_go = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; refresh_go = 1'b0;
            for (int c = 0; c < 30; c++) begin
                if (op_done) seen_op++;
                if (walk_done) seen_walk++;
                @(negedge clk);
            end
            check("R11 request served", seen_op, 1);
            check("R11 refresh_go dropped", seen_walk, 0);
        end

        finish_run();
    end
endmodule